// File: doc/BRIEF.md
# Signed-Digit Radix-10 Partial Product Selector

This block is the partial product generation stage of a parallel decimal multiplier. It takes a BCD multiplier of `NDIG` digits and a set of precomputed multiplicand multiples (1X to 5X, each given in a 4-2-2-1 decimal digit code) and returns `NDIG+1` partial product rows ready for a carry-save reduction tree. The block is purely combinational.

Each multiplier digit is rewritten as a signed digit between -5 and +5. A digit of 5 or more passes a transfer of one to the next higher position. This way only the magnitudes 0 to 5 are ever selected. A negative signed digit is produced by flipping every bit of the selected multiple. The chosen 4-2-2-1 code is self-complementing, so the flip yields the nine's complement of each digit. The row is then filled above its top digit with nines, and a separate hot-one bit per row supplies the missing +1 at the row's least significant position. The last transfer out of the top digit forms one more row, which is either zero or 1X.

Rows are delivered unshifted. The reduction stage applies the weight 10^i to row i and to hot-one bit i. Generating the multiples and reducing the rows happen elsewhere.

Top module: `sd10_pp_select`

## Requirements
- R1: For multiplier digit y_i (bits [4i+3:4i] of `mplr_bcd`), the transfer is t_i = 1 exactly when y_i >= 5. The signed digit is s_i = y_i - 10*t_i + t_(i-1), with no transfer into digit 0, which keeps every s_i within -5..+5.
- R2: For 0 <= i < NDIG, the low NDIG+1 digits of row i hold the multiple |s_i|*X, taken from the input `mcand_m1`..`mcand_m5`, or zero when s_i = 0, whenever s_i >= 0.
- R3: When s_i < 0, every bit of the selected multiple is inverted in row i (the nine's complement of each digit) and `pp_hot[i]` is 1.
- R4: When s_i >= 0, `pp_hot[i]` is 0 and every digit of row i above digit NDIG is zero.
- R5: When s_i < 0, every digit of row i above digit NDIG is 1111 (nine), filling the row to 2*NDIG digits.
- R6: A signed digit of zero gives an all-zero row and a hot-one of 0, even when its transfer t_i is 1 (y_i = 9 with a transfer in).
- R7: Row NDIG equals X when t_(NDIG-1) = 1 and zero otherwise, and `pp_hot[NDIG]` is always 0.
- R8: Digits use the 4-2-2-1 code with bit 3 weighted 4, bits 2 and 1 weighted 2 each and bit 0 weighted 1. Inputs must use the codes 0=0000, 1=0001, 2=0100, 3=0101, 4=1000, 5=0111, 6=1010, 7=1011, 8=1110, 9=1111, in which bit inversion maps v to 9-v.
- R9: The sum over i of (value of row i + `pp_hot[i]`) * 10^i equals X*Y modulo 10^(2*NDIG).
- R10: With all inputs zero, every row and every hot-one bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mplr_bcd | input | 4*NDIG | Multiplier Y in BCD, digit i at bits [4i+3:4i] |
| mcand_m1 | input | 4*(NDIG+1) | Multiple 1X in 4-2-2-1, digit j at bits [4j+3:4j] |
| mcand_m2 | input | 4*(NDIG+1) | Multiple 2X in 4-2-2-1 |
| mcand_m3 | input | 4*(NDIG+1) | Multiple 3X in 4-2-2-1 |
| mcand_m4 | input | 4*(NDIG+1) | Multiple 4X in 4-2-2-1 |
| mcand_m5 | input | 4*(NDIG+1) | Multiple 5X in 4-2-2-1 |
| pp_rows | output | (NDIG+1)*8*NDIG | Row i at bits [i*8*NDIG +: 8*NDIG], 2*NDIG digits of 4-2-2-1 |
| pp_hot | output | NDIG+1 | Hot-one bit i, weight 10^i, set for negative rows |

## Verification
The block has no storage, so a fault in the transfer chain or in the magnitude selection shows at the ports as soon as the inputs settle. A bad transfer moves a row's value by ten times X and changes the hot-one bit of the row above. The weighted sum of the rows then misses X*Y by a multiple of X. A broken inversion or a wrong fill digit shows up in the high digits of the affected row, because a negative row must read as nines there. Multiplier patterns that hold all fives, all nines, all fours and single large digits drive every transfer case, including a zero digit that still carries a transfer. The per-row values are checked alongside the total sum.

// File: rtl/sd10_pkg.sv
// Package: shared digit types and constants for the signed-digit selector.
// Assumes the self-complementing 4-2-2-1 digit code listed in the brief.
package sd10_pkg;
    localparam int DIG_W   = 4;            // bits per decimal digit
    localparam int MAG_MAX = 5;            // largest signed-digit magnitude

    typedef logic [DIG_W-1:0]   dig4_t;    // one decimal digit
    typedef logic [MAG_MAX:1]   mag_sel_t; // one-hot magnitude, bit k selects kX

    localparam dig4_t BCD_FIVE  = 4'd5;
    localparam dig4_t BCD_NINE  = 4'd9;
    localparam dig4_t NINE_CODE = 4'b1111; // nine in the 4-2-2-1 code
endpackage

// File: rtl/sd10_digit_recode.sv
// Recodes one BCD multiplier digit into a signed radix-10 digit.
// Emits the transfer to the next position, a negative flag and a one-hot
// magnitude select (1..5). Assumes the input digit is valid BCD (0..9).
// A zero magnitude is never flagged negative.
module sd10_digit_recode
    import sd10_pkg::*;
(
    input  dig4_t    bcd_digit,
    input  logic     xfer_in,
    output logic     xfer_out,
    output logic     neg,
    output mag_sel_t mag_sel
);
    logic [4:0] raw_mag;
    logic       is_big;

    // Decide the transfer and compute the signed digit magnitude.
    always_comb begin
        is_big = (bcd_digit >= BCD_FIVE);
        if (is_big)
            raw_mag = 5'd10 - {1'b0, bcd_digit} - {4'b0000, xfer_in};
        else
            raw_mag = {1'b0, bcd_digit} + {4'b0000, xfer_in};
    end

    assign xfer_out = is_big;

    // Negative only when the transfer is taken and the magnitude is nonzero.
    assign neg = is_big && (raw_mag != 5'd0);

    // Turn the magnitude into a one-hot multiple select.
    always_comb begin
        mag_sel = '0;
        for (int k = 1; k <= MAG_MAX; k++) begin
            if (raw_mag == 5'(k))
                mag_sel[k] = 1'b1;
        end
    end

    // Guards on the recoded outputs.
    always_comb begin
        // R1
        bcd_legal_chk: assert (bcd_digit <= BCD_NINE)
            else $error("multiplier digit is not BCD");
        // R1
        mag_onehot_chk: assert ($onehot0(mag_sel))
            else $error("signed digit magnitude outside 0..5");
        // R6
        neg_nonzero_chk: assert (!neg || (mag_sel != '0))
            else $error("negative flag on a zero digit");
        // R1
        neg_needs_xfer_chk: assert (!neg || xfer_out)
            else $error("negative digit without an outgoing transfer");
    end
endmodule

// File: rtl/sd10_row_select.sv
// Builds one partial product row. It selects a multiple by the one-hot
// magnitude, inverts it when the signed digit is negative, and fills the
// digits above the multiple with the sign (nines or zeros).
// Assumes ROW_DIG >= SRC_DIG and inputs in the self-complementing code.
module sd10_row_select
    import sd10_pkg::*;
#(
    parameter int SRC_DIG = 5,
    parameter int ROW_DIG = 8
) (
    input  logic [SRC_DIG*DIG_W-1:0] mult1,
    input  logic [SRC_DIG*DIG_W-1:0] mult2,
    input  logic [SRC_DIG*DIG_W-1:0] mult3,
    input  logic [SRC_DIG*DIG_W-1:0] mult4,
    input  logic [SRC_DIG*DIG_W-1:0] mult5,
    input  mag_sel_t                 mag_sel,
    input  logic                     neg,
    output logic [ROW_DIG*DIG_W-1:0] row,
    output logic                     hot
);
    localparam int SRC_W   = SRC_DIG * DIG_W;
    localparam int ROW_W   = ROW_DIG * DIG_W;
    localparam int EXT_DIG = ROW_DIG - SRC_DIG;

    logic [SRC_W-1:0] picked;

    // AND-OR selection of one multiple. No select bit gives zero.
    always_comb begin
        picked = ({SRC_W{mag_sel[1]}} & mult1)
               | ({SRC_W{mag_sel[2]}} & mult2)
               | ({SRC_W{mag_sel[3]}} & mult3)
               | ({SRC_W{mag_sel[4]}} & mult4)
               | ({SRC_W{mag_sel[5]}} & mult5);
    end

    // Per-digit conditional inversion (nine's complement in this code).
    for (genvar j = 0; j < SRC_DIG; j++) begin : g_flip
        assign row[j*DIG_W +: DIG_W] = picked[j*DIG_W +: DIG_W] ^ {DIG_W{neg}};
    end

    // Sign fill above the multiple: nine for negative rows, zero otherwise.
    for (genvar j = SRC_DIG; j < ROW_DIG; j++) begin : g_fill
        assign row[j*DIG_W +: DIG_W] = neg ? NINE_CODE : '0;
    end

    // The hot-one completes the ten's complement of a negative row.
    assign hot = neg;

    // Guards on the row contents.
    always_comb begin
        // R6
        zero_row_chk: assert (!((mag_sel == '0) && !neg) || (row == '0))
            else $error("zero digit produced a nonzero row");
        // R3
        hot_follows_neg_chk: assert (hot == neg)
            else $error("hot-one does not match the row sign");
    end

    if (EXT_DIG > 0) begin : g_fill_chk
        always_comb begin
            // R5
            neg_fill_chk: assert (!neg || (row[ROW_W-1:SRC_W] == '1))
                else $error("negative row not filled with nines");
        end
    end
endmodule

// File: rtl/sd10_pp_select.sv
// Top level of the signed-digit radix-10 partial product selector.
// It chains NDIG digit recoders through their transfers and builds NDIG
// signed rows plus one leading row (0 or X) from the last transfer.
// Rows are 2*NDIG digits wide and unshifted. Assumes NDIG >= 2, a valid
// BCD multiplier and multiples in the self-complementing 4-2-2-1 code.
module sd10_pp_select
    import sd10_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic [NDIG*DIG_W-1:0]                 mplr_bcd,
    input  logic [(NDIG+1)*DIG_W-1:0]             mcand_m1,
    input  logic [(NDIG+1)*DIG_W-1:0]             mcand_m2,
    input  logic [(NDIG+1)*DIG_W-1:0]             mcand_m3,
    input  logic [(NDIG+1)*DIG_W-1:0]             mcand_m4,
    input  logic [(NDIG+1)*DIG_W-1:0]             mcand_m5,
    output logic [(NDIG+1)*2*NDIG*DIG_W-1:0]      pp_rows,
    output logic [NDIG:0]                         pp_hot
);
    localparam int MDIG  = NDIG + 1;          // digits per multiple
    localparam int PDIG  = 2 * NDIG;          // digits per row
    localparam int ROW_W = PDIG * DIG_W;
    localparam int MW    = MDIG * DIG_W;
    localparam int NROW  = NDIG + 1;

    logic [NDIG:0]          xfer;             // xfer[i] enters digit i
    logic [NROW*MAG_MAX-1:0] mag_flat;
    logic [NDIG:0]          neg_v;

    // No transfer enters the least significant digit.
    assign xfer[0] = 1'b0;

    // Signed-digit recoding chain.
    for (genvar i = 0; i < NDIG; i++) begin : g_rec
        mag_sel_t ms;
        sd10_digit_recode u_rec (
            .bcd_digit (mplr_bcd[i*DIG_W +: DIG_W]),
            .xfer_in   (xfer[i]),
            .xfer_out  (xfer[i+1]),
            .neg       (neg_v[i]),
            .mag_sel   (ms)
        );
        assign mag_flat[i*MAG_MAX +: MAG_MAX] = ms;
    end

    // Leading row: the final transfer selects 1X, and it is never negative.
    assign mag_flat[NDIG*MAG_MAX +: MAG_MAX] = {{(MAG_MAX-1){1'b0}}, xfer[NDIG]};
    assign neg_v[NDIG] = 1'b0;

    // One row builder per partial product.
    for (genvar i = 0; i < NROW; i++) begin : g_row
        sd10_row_select #(
            .SRC_DIG (MDIG),
            .ROW_DIG (PDIG)
        ) u_row (
            .mult1   (mcand_m1),
            .mult2   (mcand_m2),
            .mult3   (mcand_m3),
            .mult4   (mcand_m4),
            .mult5   (mcand_m5),
            .mag_sel (mag_flat[i*MAG_MAX +: MAG_MAX]),
            .neg     (neg_v[i]),
            .row     (pp_rows[i*ROW_W +: ROW_W]),
            .hot     (pp_hot[i])
        );
    end

    // Guards across rows.
    always_comb begin
        // R7
        lead_hot_chk: assert (pp_hot[NDIG] == 1'b0)
            else $error("leading row flagged negative");
        // R7
        lead_row_chk: assert (xfer[NDIG] || (pp_rows[NDIG*ROW_W +: ROW_W] == '0))
            else $error("leading row nonzero without a transfer");
        for (int i = 0; i < NROW; i++) begin
            // R4
            pos_fill_chk: assert (pp_hot[i] || (pp_rows[i*ROW_W + MW +: ROW_W - MW] == '0))
                else $error("nonnegative row has nonzero upper digits");
        end
    end
endmodule

// File: tb/sd10_pp_select_test.sv
// Bench for sd10_pp_select: a table of products walked by one loop, then
// directed checks of rows, hot-ones and codes for chosen multiplier digits.
module sd10_pp_select_test;
    localparam int ND   = 4;
    localparam int MD   = ND + 1;
    localparam int PD   = 2 * ND;
    localparam int RW   = PD * 4;
    localparam int NT   = 10;
    localparam longint MODV = 64'd100000000;

    localparam logic [15:0] TX [NT] = '{16'h0000, 16'h1234, 16'h9999, 16'h5555, 16'h0001,
                                        16'h9999, 16'h4321, 16'h7777, 16'h1000, 16'h2468};
    localparam logic [15:0] TY [NT] = '{16'h0000, 16'h5678, 16'h9999, 16'h5555, 16'h9999,
                                        16'h0001, 16'h0505, 16'h7777, 16'h5000, 16'h9595};
    localparam longint      TP [NT] = '{0, 7006652, 99980001, 30858025, 9999,
                                        9999, 2182105, 60481729, 5000000, 23680460};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ND*4-1:0]       y_in;
    logic [MD*4-1:0]       m1, m2, m3, m4, m5;
    logic [(ND+1)*RW-1:0]  rows;
    logic [ND:0]           hot;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sd10_pp_select #(.NDIG(ND)) uut (
        .mplr_bcd (y_in),
        .mcand_m1 (m1),
        .mcand_m2 (m2),
        .mcand_m3 (m3),
        .mcand_m4 (m4),
        .mcand_m5 (m5),
        .pp_rows  (rows),
        .pp_hot   (hot)
    );

    function automatic logic [3:0] enc4221(int v);
        case (v)
            0: return 4'b0000;  1: return 4'b0001;  2: return 4'b0100;
            3: return 4'b0101;  4: return 4'b1000;  5: return 4'b0111;
            6: return 4'b1010;  7: return 4'b1011;  8: return 4'b1110;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic int bcd2int(logic [15:0] b);
        int v = 0;
        for (int j = 3; j >= 0; j--) v = v * 10 + int'(b[j*4 +: 4]);
        return v;
    endfunction

    function automatic logic [MD*4-1:0] enc_mult(int v);
        logic [MD*4-1:0] r = '0;
        int t = v;
        for (int j = 0; j < MD; j++) begin
            r[j*4 +: 4] = enc4221(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic longint row_val(int i);
        longint v = 0;
        longint w = 1;
        for (int j = 0; j < PD; j++) begin
            logic [3:0] d = rows[i*RW + j*4 +: 4];
            v = v + w * longint'(4*d[3] + 2*d[2] + 2*d[1] + d[0]);
            w = w * 10;
        end
        return v;
    endfunction

    function automatic longint total_sum();
        longint s = 0;
        longint w = 1;
        for (int i = 0; i <= ND; i++) begin
            s = (s + (row_val(i) + longint'(hot[i])) * w) % MODV;
            w = w * 10;
        end
        return s;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(logic [15:0] x, logic [15:0] y);
        int xi;
        @(posedge clk);
        xi = bcd2int(x);
        y_in = y;
        m1 = enc_mult(xi);
        m2 = enc_mult(2 * xi);
        m3 = enc_mult(3 * xi);
        m4 = enc_mult(4 * xi);
        m5 = enc_mult(5 * xi);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        y_in = '0; m1 = '0; m2 = '0; m3 = '0; m4 = '0; m5 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: all-zero inputs give zero rows and hot-ones
        chk("R10 rows", longint'(rows != '0), 0);
        chk("R10 hot", longint'(hot), 0);

        // R9: weighted sum equals the product for the table
        for (int t = 0; t < NT; t++) begin
            apply(TX[t], TY[t]);
            chk("R9 product", total_sum(), TP[t]);
        end

        // R3 R5: y=0009 -> s0=-1, row0 is -1X, row1 is +1X from transfer
        apply(16'h1234, 16'h0009);
        chk("R3 R5 row0 negative 1X", row_val(0), 99998765);
        chk("R3 hot vector", longint'(hot), 1);
        chk("R1 row1 transfer", row_val(1), 1234);

        // R3 R2: y=0007 -> s0=-3 selects 3X and inverts
        apply(16'h1234, 16'h0007);
        chk("R3 row0 negative 3X", row_val(0), 99996297);
        chk("R1 row1 transfer", row_val(1), 1234);

        // R2 R4: y=0003 -> +3X, positive, no hot-one
        apply(16'h1234, 16'h0003);
        chk("R2 row0 3X", row_val(0), 3702);
        chk("R4 hot zero", longint'(hot), 0);

        // R1 R7: y=5555 -> digits -5,-4,-4,-4 and leading X
        apply(16'h1234, 16'h5555);
        chk("R1 row0 negative 5X", row_val(0), 99993829);
        chk("R1 row1 negative 4X", row_val(1), 99995063);
        chk("R7 leading row X", row_val(4), 1234);
        chk("R3 hot vector", longint'(hot), 15);

        // R6: y=9999 -> digits -1,0,0,0, zero rows carry no hot-one
        apply(16'h1234, 16'h9999);
        chk("R6 row1 zero", row_val(1), 0);
        chk("R6 row2 zero", row_val(2), 0);
        chk("R6 row3 zero", row_val(3), 0);
        chk("R6 hot vector", longint'(hot), 1);
        chk("R7 leading row X", row_val(4), 1234);

        // R4 R7: y=4444 -> all positive, no leading row
        apply(16'h1234, 16'h4444);
        chk("R4 row0 4X no fill", row_val(0), 4936);
        chk("R7 leading row zero", row_val(4), 0);
        chk("R4 hot zero", longint'(hot), 0);

        // R7 R5: y=5000 -> only digit 3 negative, leading X
        apply(16'h1234, 16'h5000);
        chk("R5 row3 negative 5X", row_val(3), 99993829);
        chk("R7 leading row X", row_val(4), 1234);
        chk("R3 hot vector", longint'(hot), 8);

        // R8: bit-level code, x=9, y=6 -> s0=-4, 4X=36, digit 6 (1010) inverts to 0101
        apply(16'h0009, 16'h0006);
        chk("R8 row0 digit0 code", longint'(rows[3:0]), 5);
        chk("R8 row0 digit7 code", longint'(rows[31:28]), 15);
        chk("R9 product", total_sum(), 54);

        finish_run();
    end
endmodule